// File: doc/BRIEF.md
# System Exception Control and Status Register

This block is the software-visible word through which a processor core's system exceptions are pended, unpended and inspected. Reads return a snapshot assembled from the interrupt controller's state. The snapshot holds the vector number of the running exception and the vector number of the highest pending exception. It also shows whether any external interrupt line waits, whether the running handler sits on an empty stack of preempted handlers, and the pending state of the non-maskable, pendable-service and tick exceptions.

Writes never change the register itself. Each 1 in a command bit turns into a one-cycle set or clear strobe toward the interrupt controller, which owns the pending flags. The controller numbers its lines internally, with external interrupts starting at line 32. Software sees vector numbers, with external interrupts starting at 16. The block converts between the two numberings on the read path. Arbitration and vector fetch stay in the controller.

Top module: `sysexc_csr`

## Requirements
- R1: Read bits 8:0 hold the vector number of the active exception, or 0 when `activeValid` is low. An internal line of 32 or above reads as line minus 16, and a line below 32 reads unchanged.
- R2: Read bit 11 is 1 when no exception is active, or when the active one has no preempted exception beneath it (`activeHasPrior` low). Otherwise it is 0.
- R3: Read bits 20:12 hold the vector number of the highest pending exception, with the same translation as R1, or 0 when `pendValid` is low.
- R4: Read bit 22 is 1 exactly when at least one bit of `extPend` is set.
- R5: Read bits 26, 28 and 31 equal `sysPend[0]` (tick), `sysPend[1]` (pendable service) and `sysPend[2]` (non-maskable).
- R6: A write with bit 31 set raises `setStrobe[2]` (non-maskable) in the cycle after the write edge.
- R7: A write with bit 28 set raises `setStrobe[1]`. A write with bit 27 set raises `clrStrobe[1]` only when bit 28 of the same write is clear.
- R8: A write with bit 26 set raises `setStrobe[0]`. A write with bit 25 set raises `clrStrobe[0]` only when bit 26 of the same write is clear.
- R9: Strobes last exactly one cycle. None is raised in a cycle that follows an edge without `wrEn`, whatever `wrData` holds, and a 0 written to a command bit raises nothing.
- R10: Read bits 10:9, 21, 23:25, 27, 29 and 30 read 0. A write whose only 1s lie outside bits 31, 28, 27, 26 and 25 raises no strobe.
- R11: While `rstN` is low, all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write access to the register in this cycle |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Assembled read value (combinational) |
| sysPend | input | 3 | Pending flags: [2] non-maskable, [1] pendable service, [0] tick |
| extPend | input | NUM_EXT (64) | Pending flags of external interrupt lines |
| activeValid | input | 1 | An exception is active |
| activeLine | input | LINE_W (7) | Internal line index of the active exception |
| activeHasPrior | input | 1 | The active exception preempted another one |
| pendValid | input | 1 | An exception is pending |
| pendLine | input | LINE_W (7) | Internal line index of the highest pending exception |
| setStrobe | output | 3 | Set-pending pulses: [2] non-maskable, [1] pendable service, [0] tick |
| clrStrobe | output | 2 | Clear-pending pulses: [1] pendable service, [0] tick |

## Verification
The read-side properties rely on the controller to present a line index only when the matching valid flag is high. They also rely on that index never falling in the unused range 16 to 31 for pending external lines. The bench table keeps to these rules, except for one row that drives a stale `activeLine` with `activeValid` low to show that the index is ignored. The write-side properties rely on `wrEn` being a plain per-cycle qualifier. The stimulus therefore holds it for exactly one cycle per access and leaves `wrData` at all ones in between, which exposes any decode that ignores the qualifier.

// File: rtl/sysexc_pkg.sv
package sysexc_pkg;

  // Field positions on the read side
  localparam int ACT_LSB   = 0;
  localparam int BASE_BIT  = 11;
  localparam int PEND_LSB  = 12;
  localparam int EXTP_BIT  = 22;
  localparam int TICKP_BIT = 26;
  localparam int SVCP_BIT  = 28;
  localparam int NMIP_BIT  = 31;
  localparam int VEC_W     = 9;

  // Command bits on the write side
  localparam int CLR_TICK_BIT = 25;
  localparam int SET_TICK_BIT = 26;
  localparam int CLR_SVC_BIT  = 27;
  localparam int SET_SVC_BIT  = 28;
  localparam int SET_NMI_BIT  = 31;

  // Numbering between internal lines and software vectors
  localparam int EXT_FIRST_LINE = 32;
  localparam int VEC_SHIFT      = 16;

  typedef struct packed {
    logic setNmi;
    logic setSvc;
    logic setTick;
    logic clrSvc;
    logic clrTick;
  } strobe_t;

endpackage

// File: rtl/sysexc_wr_ctrl.sv
module sysexc_wr_ctrl
  import sysexc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrEn,
  input  logic    cmdNmi,
  input  logic    cmdSetSvc,
  input  logic    cmdClrSvc,
  input  logic    cmdSetTick,
  input  logic    cmdClrTick,
  output strobe_t strb
);

  strobe_t nextStrb;

  // A set request wins over a clear written in the same access.
  always_comb begin
    nextStrb         = '0;
    nextStrb.setNmi  = wrEn & cmdNmi;
    nextStrb.setSvc  = wrEn & cmdSetSvc;
    nextStrb.clrSvc  = wrEn & cmdClrSvc & ~cmdSetSvc;
    nextStrb.setTick = wrEn & cmdSetTick;
    nextStrb.clrTick = wrEn & cmdClrTick & ~cmdSetTick;
  end

  always_ff @(posedge clk) begin
    if (!rstN) strb <= '0;
    else       strb <= nextStrb;
  end

endmodule

// File: rtl/sysexc_rd_path.sv
module sysexc_rd_path
  import sysexc_pkg::*;
#(
  parameter int NUM_EXT = 64,
  parameter int LINE_W  = 7
) (
  input  strobe_t             strb,
  input  logic [2:0]          sysPend,
  input  logic [NUM_EXT-1:0]  extPend,
  input  logic                activeValid,
  input  logic [LINE_W-1:0]   activeLine,
  input  logic                activeHasPrior,
  input  logic                pendValid,
  input  logic [LINE_W-1:0]   pendLine,
  output logic [31:0]         rdData,
  output logic [2:0]          setStrobe,
  output logic [1:0]          clrStrobe
);

  logic [VEC_W-1:0] actVec;
  logic [VEC_W-1:0] pendVec;
  logic             anyExt;

  // Internal line index to software vector number
  function automatic logic [VEC_W-1:0] lineToVec(input logic [LINE_W-1:0] line);
    logic [VEC_W-1:0] wide;
    wide = VEC_W'(line);
    if (wide >= VEC_W'(EXT_FIRST_LINE)) return wide - VEC_W'(VEC_SHIFT);
    return wide;
  endfunction

  generate
    if (NUM_EXT > 0) begin : g_ext
      assign anyExt = |extPend;
    end else begin : g_noext
      assign anyExt = 1'b0;
    end
  endgenerate

  assign actVec  = activeValid ? lineToVec(activeLine) : '0;
  assign pendVec = pendValid   ? lineToVec(pendLine)   : '0;

  always_comb begin
    rdData                          = '0;
    rdData[ACT_LSB +: VEC_W]        = actVec;
    rdData[BASE_BIT]                = ~activeValid | ~activeHasPrior;
    rdData[PEND_LSB +: VEC_W]       = pendVec;
    rdData[EXTP_BIT]                = anyExt;
    rdData[TICKP_BIT]               = sysPend[0];
    rdData[SVCP_BIT]                = sysPend[1];
    rdData[NMIP_BIT]                = sysPend[2];
  end

  assign setStrobe = {strb.setNmi, strb.setSvc, strb.setTick};
  assign clrStrobe = {strb.clrSvc, strb.clrTick};

endmodule

// File: rtl/sysexc_csr.sv
module sysexc_csr
  import sysexc_pkg::*;
#(
  parameter int NUM_EXT = 64,
  localparam int LINE_W = $clog2(EXT_FIRST_LINE + NUM_EXT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  input  logic [2:0]         sysPend,
  input  logic [NUM_EXT-1:0] extPend,
  input  logic               activeValid,
  input  logic [LINE_W-1:0]  activeLine,
  input  logic               activeHasPrior,
  input  logic               pendValid,
  input  logic [LINE_W-1:0]  pendLine,
  output logic [2:0]         setStrobe,
  output logic [1:0]         clrStrobe
);

  strobe_t strb;

  sysexc_wr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .cmdNmi     (wrData[SET_NMI_BIT]),
    .cmdSetSvc  (wrData[SET_SVC_BIT]),
    .cmdClrSvc  (wrData[CLR_SVC_BIT]),
    .cmdSetTick (wrData[SET_TICK_BIT]),
    .cmdClrTick (wrData[CLR_TICK_BIT]),
    .strb       (strb)
  );

  sysexc_rd_path #(.NUM_EXT(NUM_EXT), .LINE_W(LINE_W)) u_rd (
    .strb           (strb),
    .sysPend        (sysPend),
    .extPend        (extPend),
    .activeValid    (activeValid),
    .activeLine     (activeLine),
    .activeHasPrior (activeHasPrior),
    .pendValid      (pendValid),
    .pendLine       (pendLine),
    .rdData         (rdData),
    .setStrobe      (setStrobe),
    .clrStrobe      (clrStrobe)
  );

endmodule

// File: rtl/sysexc_csr_chk.sv
module sysexc_csr_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [31:0] wrData,
  input logic [31:0] rdData,
  input logic [2:0]  sysPend,
  input logic        activeValid,
  input logic        pendValid,
  input logic [2:0]  setStrobe,
  input logic [1:0]  clrStrobe
);

  localparam logic [31:0] CMD_MASK  = 32'h9E00_0000;
  localparam logic [31:0] RSVD_MASK = 32'h6BA0_0600;

  // R1
  act_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !activeValid |-> rdData[8:0] == 9'd0);

  // R2
  base_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !activeValid |-> rdData[11]);

  // R3
  pend_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pendValid |-> rdData[20:12] == 9'd0);

  // R5
  sys_mirror_chk: assert property (@(posedge clk) disable iff (!rstN)
    {rdData[31], rdData[28], rdData[26]} == sysPend);

  // R6
  nmi_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[31]) |=> setStrobe[2]);

  // R7
  svc_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(setStrobe[1] && clrStrobe[1]));

  // R8
  tick_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(setStrobe[0] && clrStrobe[0]));

  // R9
  strobe_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> (setStrobe == 3'b000 && clrStrobe == 2'b00));

  // R10
  rsvd_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrData & CMD_MASK) == 32'd0) |=> (setStrobe == 3'b000 && clrStrobe == 2'b00));

  // R10
  rsvd_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & RSVD_MASK) == 32'd0);

endmodule

bind sysexc_csr sysexc_csr_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .wrData      (wrData),
  .rdData      (rdData),
  .sysPend     (sysPend),
  .activeValid (activeValid),
  .pendValid   (pendValid),
  .setStrobe   (setStrobe),
  .clrStrobe   (clrStrobe)
);

// File: tb/sysexc_csr_tb.sv
module sysexc_csr_tb;

  localparam int NUM_EXT = 64;
  localparam int LINE_W  = 7;
  localparam int ENT_W   = 1 + LINE_W + 1 + 1 + LINE_W + 3 + NUM_EXT + 32;

  logic               clk = 1'b0;
  logic               rstN;
  logic               wrEn;
  logic [31:0]        wrData;
  logic [31:0]        rdData;
  logic [2:0]         sysPend;
  logic [NUM_EXT-1:0] extPend;
  logic               activeValid;
  logic [LINE_W-1:0]  activeLine;
  logic               activeHasPrior;
  logic               pendValid;
  logic [LINE_W-1:0]  pendLine;
  logic [2:0]         setStrobe;
  logic [1:0]         clrStrobe;

  int  testCnt = 0;
  int  failCnt = 0;
  bit  done    = 1'b0;

  always #2 clk = ~clk;

  sysexc_csr #(.NUM_EXT(NUM_EXT)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .sysPend(sysPend), .extPend(extPend), .activeValid(activeValid),
    .activeLine(activeLine), .activeHasPrior(activeHasPrior),
    .pendValid(pendValid), .pendLine(pendLine),
    .setStrobe(setStrobe), .clrStrobe(clrStrobe)
  );

  // {activeValid, activeLine, activeHasPrior, pendValid, pendLine, sysPend, extPend, expected rdData}
  localparam logic [ENT_W-1:0] TBL [6] = '{
    {1'b0, 7'd0,  1'b0, 1'b0, 7'd0,  3'b000, 64'd0,       32'h0000_0800}, // R2 idle, R1/R3 zero
    {1'b1, 7'd15, 1'b1, 1'b1, 7'd14, 3'b010, 64'd0,       32'h1000_E00F}, // R1 R3 low lines, R5 svc
    {1'b1, 7'd32, 1'b0, 1'b1, 7'd95, 3'b100, 64'd1 << 63, 32'h8044_F810}, // R1 R3 shift, R4, R5 nmi
    {1'b1, 7'd3,  1'b1, 1'b1, 7'd15, 3'b001, 64'd1,       32'h0440_F003}, // R2 nested, R4, R5 tick
    {1'b0, 7'd50, 1'b1, 1'b0, 7'd40, 3'b000, 64'd1 << 8,  32'h0040_0800}, // R1 stale line ignored
    {1'b1, 7'd31, 1'b0, 1'b1, 7'd33, 3'b111, 64'd2,       32'h9441_181F}  // R1 line 31 unshifted, R3 33->17
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [31:0] d, input logic [2:0] es,
                         input logic [1:0] ec, input string tag);
    @(negedge clk);
    wrEn   = 1'b1;
    wrData = d;
    @(negedge clk);
    check({27'd0, setStrobe, clrStrobe}, {27'd0, es, ec}, tag);
    wrEn   = 1'b0;
    wrData = 32'hFFFF_FFFF;
    @(negedge clk);
    // R9 pulse ends after one cycle, and no write means no strobe
    check({27'd0, setStrobe, clrStrobe}, 32'd0, {tag, " R9 pulse end"});
  endtask

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrData = 32'd0;
    sysPend = '0; extPend = '0; activeValid = 1'b0; activeLine = '0;
    activeHasPrior = 1'b0; pendValid = 1'b0; pendLine = '0;

    // R11 reset holds strobes low even with a write request present
    repeat (2) @(negedge clk);
    wrEn = 1'b1; wrData = 32'hFFFF_FFFF;
    @(negedge clk);
    check({27'd0, setStrobe, clrStrobe}, 32'd0, "R11 strobes in reset");
    check(rdData, 32'h0000_0800, "R11 R2 read at reset");
    wrEn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      logic [31:0] expRd;
      @(negedge clk);
      {activeValid, activeLine, activeHasPrior, pendValid, pendLine,
       sysPend, extPend, expRd} = TBL[i];
      #1;
      check(rdData, expRd, $sformatf("R1 R2 R3 R4 R5 table row %0d", i));
    end

    // R10 read reserved bits stay zero with every input asserted
    @(negedge clk);
    activeValid = 1'b1; activeLine = 7'd127; activeHasPrior = 1'b1;
    pendValid = 1'b1; pendLine = 7'd127; sysPend = 3'b111; extPend = '1;
    #1;
    check(rdData & 32'h6BA0_0600, 32'd0, "R10 reserved read bits");
    check(rdData[20:12], 9'd111, "R3 top line translation");

    doWrite(32'h8000_0000, 3'b100, 2'b00, "R6 set nmi");
    doWrite(32'h1000_0000, 3'b010, 2'b00, "R7 set svc");
    doWrite(32'h0800_0000, 3'b000, 2'b10, "R7 clear svc");
    doWrite(32'h1800_0000, 3'b010, 2'b00, "R7 set overrides clear");
    doWrite(32'h0400_0000, 3'b001, 2'b00, "R8 set tick");
    doWrite(32'h0200_0000, 3'b000, 2'b01, "R8 clear tick");
    doWrite(32'h0600_0000, 3'b001, 2'b00, "R8 set overrides clear");
    doWrite(32'h0A00_0000, 3'b000, 2'b11, "R7 R8 clear both");
    doWrite(32'h0000_0000, 3'b000, 2'b00, "R9 zero write");
    doWrite(32'h61FF_FFFF, 3'b000, 2'b00, "R10 reserved write");
    doWrite(32'hFFFF_FFFF, 3'b111, 2'b00, "R6 R7 R8 all ones");

    // R9 back-to-back writes give one pulse per write
    @(negedge clk);
    wrEn = 1'b1; wrData = 32'h1000_0000;
    @(negedge clk);
    check({29'd0, setStrobe}, 32'd2, "R9 first of pair");
    wrData = 32'h0200_0000;
    @(negedge clk);
    check({27'd0, setStrobe, clrStrobe}, 32'd1, "R9 second of pair");
    wrEn = 1'b0;
    @(negedge clk);
    check({27'd0, setStrobe, clrStrobe}, 32'd0, "R9 after pair");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

endmodule